// File: doc/BRIEF.md
# Watchdog Timer with Guarded Disable

This block watches for stalled software. Once enabled, a counter advances on every cycle in which an independent oscillator tick enable is high. If software does not restart the counter with a clear strobe before the selected timeout is reached, the block drives a fixed-length system reset pulse and sets a sticky status flag. The timeout is one of eight periods picked by a 3-bit select, and each step doubles the period.

Configuration arrives through a single-cycle register write port that carries a timeout select, an enable bit and a turn-off-enable bit. Turning the watchdog on takes one write. Turning it off needs two writes: first an arming write with both the enable and turn-off-enable bits set, then a write with the enable bit clear within a short window of system clock cycles. A bare write of zero to the enable bit does nothing, so a runaway program is unlikely to switch the watchdog off by accident. The status flag survives the watchdog's own reset pulse and is cleared only by a dedicated clear input.

Top module: `wdog_guard`

## Requirements
- R1: After `rstN` is released, the watchdog is disabled, `wdReset` and `wdFlag` are 0, and no reset pulse is produced, however long the block stays idle.
- R2: `wrData` is decoded as follows: bits [2:0] are the timeout select, bit 3 is the enable bit and bit 4 is turn-off-enable. A write with the enable bit set turns a disabled watchdog on and starts the count from zero.
- R3: With select code n, the reset pulse starts on the clock edge that counts tick number 2^(BASE_LOG2+n) since the last restart, so each code step doubles the timeout.
- R4: The count advances only in cycles where `oscTick` is high.
- R5: A `kick` pulse restarts the count from zero, and the full timeout is measured from that edge.
- R6: A write with the enable bit set and a select different from the current one loads the new select and restarts the count. Such a write with an unchanged select leaves the count undisturbed.
- R7: The reset pulse stays high for PULSE_CYC system clock cycles. The count is held at zero for the length of the pulse (a `kick` during the pulse has no effect), and a full timeout is measured again from the pulse's end.
- R8: A write with enable=1 and turn-off-enable=1 arms a window. A write with enable=0 in any of the next WINDOW_CYC cycles disables the watchdog and clears its count, and a later enable write starts a fresh timeout.
- R9: A write with enable=0 that arrives while no window is armed (including one carrying turn-off-enable=1) is ignored entirely: the watchdog keeps running, and neither the select nor the count changes.
- R10: The armed window closes by itself after WINDOW_CYC cycles. A write with enable=0 after that point is ignored, just as in R9.
- R11: `wdFlag` goes to 1 on the edge that starts a reset pulse and stays 1 after the pulse ends. Only `flagClr` clears it. If a new pulse starts in the same cycle as `flagClr`, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oscTick | input | 1 | Tick enable from the watchdog oscillator, already in the clk domain |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 5 | Write data: [2:0] select, [3] enable, [4] turn-off-enable |
| kick | input | 1 | Software clear strobe, restarts the count |
| flagClr | input | 1 | Clears the sticky status flag |
| wdReset | output | 1 | System reset pulse |
| wdFlag | output | 1 | Sticky watchdog-reset status flag |

## Verification
The bench probes both edges of the disable window, at one and at four cycles after arming, and also one cycle past it. A design with an off-by-one window would either fail to disable at the far edge or accept a late write. It sends plain zero writes and arming writes that carry enable=0. A design that decodes turn-off-enable alone would switch off, and a design that loads the select on every write would shift the measured timeout. Timeouts are measured to the exact cycle for several select codes and after kicks, select changes and same-select rewrites, which exposes a missing restart or a spurious one. The bench also holds `flagClr` high across a timeout, so a design that lets the clear beat the set would show a flag stuck at 0.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int SEL_W   = 3;
  localparam int NUM_SEL = 1 << SEL_W;
  localparam int CTRL_W  = SEL_W + 2;

  // Layout of the write data word
  typedef struct packed {
    logic             turnOff;
    logic             enable;
    logic [SEL_W-1:0] sel;
  } ctrlWord_t;

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic clear;
    logic run;
  } cntCmd_t;

endpackage

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCmd_t          cmd,
  input  logic [SEL_W-1:0] sel,
  output logic             expire
);

  localparam int CNT_W = BASE_LOG2 + NUM_SEL;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastTab [NUM_SEL];
  logic [CNT_W-1:0] lastSel;

  // Last count value before timeout for each select code
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_last
    assign lastTab[g] = (CNT_W'(1) << (BASE_LOG2 + g)) - CNT_W'(1);
  end

  assign lastSel = lastTab[sel];
  assign expire  = cmd.run & (cnt == lastSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (cmd.clear) begin
      cnt <= '0;
    end else if (cmd.run) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R3: the count never passes the limit of the current select
  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= lastSel);

  // R5: a restart leaves the count at zero
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clear |=> (cnt == '0));

  // R4: with no tick and no clear the count holds
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.run && !cmd.clear) |=> $stable(cnt));

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int WINDOW_CYC = 4,
  parameter int PULSE_CYC  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oscTick,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrData,
  input  logic              kick,
  input  logic              flagClr,
  input  logic              expire,
  output cntCmd_t           cmd,
  output logic [SEL_W-1:0]  selOut,
  output logic              enOut,
  output logic              pulseOut,
  output logic              flagOut
);

  localparam int WIN_W   = $clog2(WINDOW_CYC + 1);
  localparam int PULSE_W = $clog2(PULSE_CYC + 1);

  ctrlWord_t          wr;
  logic               enReg;
  logic [SEL_W-1:0]   selReg;
  logic [WIN_W-1:0]   winCnt;
  logic [PULSE_W-1:0] pulseCnt;
  logic               flagReg;

  logic armed, disableHit, armHit, loadSel, selChange, turnOn, restart;
  logic pulseActive;

  assign wr          = ctrlWord_t'(wrData);
  assign armed       = (winCnt != '0);
  assign disableHit  = wrEn & ~wr.enable & armed & enReg;
  assign armHit      = wrEn & wr.enable & wr.turnOff;
  assign loadSel     = wrEn & wr.enable;
  assign selChange   = loadSel & (wr.sel != selReg);
  assign turnOn      = loadSel & ~enReg;
  assign restart     = kick | selChange | disableHit | turnOn;
  assign pulseActive = (pulseCnt != '0);

  always_comb begin
    cmd.run   = enReg & ~pulseActive & oscTick & ~restart;
    cmd.clear = restart | ~enReg | pulseActive | expire;
  end

  // Enable, select and unlock window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg  <= 1'b0;
      selReg <= '0;
      winCnt <= '0;
    end else begin
      if (disableHit)   enReg <= 1'b0;
      else if (loadSel) enReg <= 1'b1;

      if (loadSel) selReg <= wr.sel;

      if (disableHit)  winCnt <= '0;
      else if (armHit) winCnt <= WIN_W'(WINDOW_CYC);
      else if (armed)  winCnt <= winCnt - WIN_W'(1);
    end
  end

  // Reset pulse and sticky flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
      flagReg  <= 1'b0;
    end else begin
      if (expire)           pulseCnt <= PULSE_W'(PULSE_CYC);
      else if (pulseActive) pulseCnt <= pulseCnt - PULSE_W'(1);

      if (expire)       flagReg <= 1'b1;
      else if (flagClr) flagReg <= 1'b0;
    end
  end

  assign selOut   = selReg;
  assign enOut    = enReg;
  assign pulseOut = pulseActive;
  assign flagOut  = flagReg;

  // R8: the watchdog turns off only while the window is open
  a_r8_off_in_window: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enReg) |-> $past(winCnt != '0));

  // R2: the watchdog turns on only through a write
  a_r2_on_by_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enReg) |-> $past(wrEn));

  // R10: the window never exceeds its length
  a_r10_window_bound: assert property (@(posedge clk) disable iff (!rstN)
    winCnt <= WIN_W'(WINDOW_CYC));

  // R7: no timeout is detected while a pulse is running
  a_r7_no_expire_in_pulse: assert property (@(posedge clk) disable iff (!rstN)
    pulseActive |-> !expire);

  // R11: a timeout always leaves the flag set
  a_r11_flag_on_expire: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> flagReg);

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2  = 14,
  parameter int WINDOW_CYC = 4,
  parameter int PULSE_CYC  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oscTick,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrData,
  input  logic              kick,
  input  logic              flagClr,
  output logic              wdReset,
  output logic              wdFlag
);

  cntCmd_t          cmd;
  logic [SEL_W-1:0] sel;
  logic             expire;
  logic             enabled;

  wdog_ctrl #(
    .WINDOW_CYC(WINDOW_CYC),
    .PULSE_CYC (PULSE_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .oscTick (oscTick),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .kick    (kick),
    .flagClr (flagClr),
    .expire  (expire),
    .cmd     (cmd),
    .selOut  (sel),
    .enOut   (enabled),
    .pulseOut(wdReset),
    .flagOut (wdFlag)
  );

  wdog_dp #(
    .BASE_LOG2(BASE_LOG2)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .cmd   (cmd),
    .sel   (sel),
    .expire(expire)
  );

  // R1: a disabled watchdog never times out
  a_r1_off_no_expire: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |-> !expire);

endmodule

// File: tb/wdog_guard_tb.sv
module wdog_guard_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BASE_LOG2  = 4;
  localparam int WINDOW_CYC = 4;
  localparam int PULSE_CYC  = 16;
  localparam int TIMEOUT    = 200000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       oscTick = 1'b1;
  logic       slowTick = 1'b0;
  logic       wrEn = 1'b0;
  logic [4:0] wrData = '0;
  logic       kick = 1'b0;
  logic       flagClr = 1'b0;
  logic       wdReset;
  logic       wdFlag;

  int checks = 0;
  int errors = 0;

  wdog_guard #(
    .BASE_LOG2 (BASE_LOG2),
    .WINDOW_CYC(WINDOW_CYC),
    .PULSE_CYC (PULSE_CYC)
  ) u_dut (
    .clk    (clk),
    .rstN   (rstN),
    .oscTick(oscTick),
    .wrEn   (wrEn),
    .wrData (wrData),
    .kick   (kick),
    .flagClr(flagClr),
    .wdReset(wdReset),
    .wdFlag (wdFlag)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (slowTick) oscTick <= ~oscTick;
    else          oscTick <= 1'b1;
  end

  function automatic int lim(input int sel);
    return 1 << (BASE_LOG2 + sel);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // All tasks start and end just after a falling edge
  task automatic doWrite(input bit en, input bit toe, input int sel);
    wrEn   = 1'b1;
    wrData = {toe, en, 3'(sel)};
    @(posedge clk);
    @(negedge clk);
    wrEn   = 1'b0;
    wrData = '0;
  endtask

  task automatic doKick();
    kick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    kick = 1'b0;
  endtask

  // Edges counted until wdReset is seen high, capped at maxN
  task automatic measure(input int maxN, output int n);
    n = 0;
    while (n < maxN) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (wdReset) break;
    end
  endtask

  task automatic hardReset();
    @(negedge clk);
    rstN = 1'b0;
    wrEn = 1'b0;
    kick = 1'b0;
    flagClr = 1'b0;
    slowTick = 1'b0;
    idle(3);
    rstN = 1'b1;
    idle(1);
  endtask

  task automatic t_reset();
    int n;
    hardReset();
    check(wdReset == 1'b0, "R1 wdReset after reset", wdReset, 0);
    check(wdFlag == 1'b0, "R1 wdFlag after reset", wdFlag, 0);
    measure(3000, n);
    check(!wdReset && n == 3000, "R1 no pulse while disabled", n, 3000);
  endtask

  task automatic t_select();
    int n;
    int codes[5] = '{0, 1, 2, 3, 7};
    foreach (codes[k]) begin
      hardReset();
      doWrite(1'b1, 1'b0, codes[k]);
      measure(4096, n);
      check(n == lim(codes[k]), $sformatf("R2 R3 timeout for code %0d", codes[k]),
            n, lim(codes[k]));
    end
  endtask

  task automatic t_tick();
    int n;
    hardReset();
    slowTick = 1'b1;
    idle(2);
    doWrite(1'b1, 1'b0, 0);
    measure(4 * lim(0), n);
    check(n > lim(0), "R4 no timeout before enough ticks", n, lim(0) + 1);
    check(n <= 2 * lim(0), "R4 timeout with half-rate ticks", n, 2 * lim(0));
    slowTick = 1'b0;
  endtask

  task automatic t_kick();
    int n;
    hardReset();
    doWrite(1'b1, 1'b0, 0);
    idle(10);
    doKick();
    measure(200, n);
    check(n == lim(0), "R5 timeout measured from kick", n, lim(0));
  endtask

  task automatic t_selchg();
    int n;
    hardReset();
    doWrite(1'b1, 1'b0, 0);
    idle(10);
    doWrite(1'b1, 1'b0, 1);
    measure(200, n);
    check(n == lim(1), "R6 select change restarts count", n, lim(1));
    hardReset();
    doWrite(1'b1, 1'b0, 1);
    idle(5);
    doWrite(1'b1, 1'b0, 1);
    measure(200, n);
    check(n == lim(1) - 6, "R6 same select keeps count", n, lim(1) - 6);
  endtask

  task automatic t_pulse();
    int n;
    int p;
    hardReset();
    doWrite(1'b1, 1'b0, 0);
    measure(200, n);
    check(n == lim(0), "R7 first timeout", n, lim(0));
    p = 1;
    while (p < 100) begin
      kick = (p == 5);
      @(posedge clk);
      @(negedge clk);
      kick = 1'b0;
      if (wdReset) p++;
      else break;
    end
    check(p == PULSE_CYC, "R7 pulse length", p, PULSE_CYC);
    measure(200, n);
    check(n == lim(0), "R7 timeout after pulse end", n, lim(0));
  endtask

  task automatic t_disable();
    int n;
    int offs[2] = '{1, 4};
    foreach (offs[k]) begin
      hardReset();
      doWrite(1'b1, 1'b0, 0);
      doWrite(1'b1, 1'b1, 0);
      idle(offs[k] - 1);
      doWrite(1'b0, 1'b0, 0);
      measure(200, n);
      check(!wdReset && n == 200, $sformatf("R8 disabled at offset %0d", offs[k]), n, 200);
      doWrite(1'b1, 1'b0, 0);
      measure(200, n);
      check(n == lim(0), "R8 fresh timeout after re-enable", n, lim(0));
    end
  endtask

  task automatic t_ignore();
    int n;
    hardReset();
    doWrite(1'b1, 1'b0, 1);
    doWrite(1'b0, 1'b0, 1);
    doWrite(1'b0, 1'b1, 3);
    measure(200, n);
    check(n == lim(1) - 2, "R9 unarmed zero writes ignored", n, lim(1) - 2);
  endtask

  task automatic t_window();
    int n;
    hardReset();
    doWrite(1'b1, 1'b0, 2);
    doWrite(1'b1, 1'b1, 2);
    idle(4);
    doWrite(1'b0, 1'b0, 2);
    doWrite(1'b0, 1'b0, 2);
    measure(300, n);
    check(n == lim(2) - 7, "R10 late zero writes ignored", n, lim(2) - 7);
  endtask

  task automatic t_flag();
    int n;
    hardReset();
    doWrite(1'b1, 1'b0, 0);
    measure(200, n);
    check(wdFlag == 1'b1, "R11 flag set with pulse", wdFlag, 1);
    idle(PULSE_CYC + 2);
    check(wdFlag == 1'b1, "R11 flag sticky after pulse", wdFlag, 1);
    flagClr = 1'b1;
    idle(1);
    flagClr = 1'b0;
    check(wdFlag == 1'b0, "R11 flag cleared by flagClr", wdFlag, 0);
    hardReset();
    doWrite(1'b1, 1'b0, 0);
    flagClr = 1'b1;
    measure(200, n);
    check(wdFlag == 1'b1, "R11 set wins over clear", wdFlag, 1);
    idle(1);
    check(wdFlag == 1'b0, "R11 held clear then clears", wdFlag, 0);
    flagClr = 1'b0;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_select();
        t_tick();
        t_kick();
        t_selchg();
        t_pulse();
        t_disable();
        t_ignore();
        t_window();
        t_flag();
      end
      begin
        repeat (TIMEOUT) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", TIMEOUT);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule